// File: doc/BRIEF.md
# Receive Pad and FCS Stripper

This block sits in the receive path between the MAC and the host memory writer. It takes a byte stream framed by start-of-frame and end-of-frame markers under a valid/ready handshake, and hands the same kind of stream downstream. When stripping is on, it reads the big-endian length/type field in frame octets 12 and 13. If that field holds a value below 46, the frame is cut to the 14-byte header plus the data bytes the field counts. The pad bytes and the trailing 4-byte FCS are both removed, because the FCS no longer covers the shortened frame.

A frame whose field is 46 or more is forwarded whole, FCS included. That covers every type code (0x0600 and up). With stripping off, every frame is forwarded whole. The end-of-frame marker moves to the last byte kept. Bytes that are dropped are taken from the input at one per cycle even while the output is stalled. The block also flags a configuration conflict whenever stripping and receive checksum offload are enabled together, because those two functions must not run at the same time.

The enable is sampled on the start-of-frame byte, so changing it in the middle of a frame has no effect on that frame. An optional output register, chosen by parameter, breaks the timing path to the consumer.

Top module: `rx_pad_strip`

## Requirements
- R1: While reset is low and on the first cycle after it rises, `out_valid` is 0. The stripping state is cleared, so the first frame after reset is handled according to the enable sampled on its own start-of-frame byte.
- R2: With stripping on and a length field L < 46 (byte 12 holds the high octet, byte 13 the low octet), the output frame has exactly 14+L bytes and `out_eof` is set on byte 14+L-1.
- R3: For such a short frame, the output bytes are the first 14+L input bytes, unchanged and in order. All pad bytes and the 4 FCS bytes are dropped.
- R4: With stripping on and 46 <= L < 0x0600, every input byte, FCS included, is forwarded unmodified.
- R5: With stripping on, a type value L >= 0x0600 is never treated as a length, and the frame is forwarded unmodified.
- R6: With stripping off, every frame is forwarded unmodified whatever its length field holds.
- R7: `cfg_conflict` is 1 exactly when `strip_en` and `csum_en` are both 1.
- R8: Every output frame starts with a byte carrying `out_sof` and ends with exactly one byte carrying `out_eof`. No start-of-frame appears inside a frame.
- R9: While `out_valid` is high and `out_ready` is low, the output byte and its markers hold steady. A byte that is being dropped is accepted (`in_ready`=1) even while the output is stalled.
- R10: `strip_en` is sampled on the start-of-frame byte. A change to it later in the frame does not alter how that frame is handled.
- R11: A frame whose input ends before byte 14+L-1 is forwarded up to its own end-of-frame byte. A length field of 0 puts `out_eof` on byte 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_en | input | 1 | Enables pad and FCS stripping of short frames |
| csum_en | input | 1 | Receive checksum offload enable, used only for the conflict flag |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last kept byte of a frame |
| cfg_conflict | output | 1 | Stripping and checksum offload are both enabled |

## Verification
Frames are sent with length fields of 0, 10, 45 and 46 and with a type code of 0x0800. Together these separate the strip and pass decisions on both sides of the 46 threshold, and they show that a type code is not read as a length. The same short field is sent once with stripping off and once with the enable toggled mid-frame in each direction, which shows that only the start-of-frame value counts. A truncated frame shows that an early end marker is still honoured. A stripped frame that has its output stalled just after the last kept byte shows that the discarded tail keeps draining. Back-to-back frames under a pseudo-random ready pattern exercise the framing markers and the way data holds during a stall.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic [BYTE_W-1:0] data;
      logic              sof;
      logic              eof;
   } rxs_beat_t;
endpackage

// File: rtl/rxs_len_decode.sv
// Captures the length/type field as it streams past and makes the strip
// decision on the beat that carries its low octet.
module rxs_len_decode #(
   parameter int CNT_W       = 16,
   parameter int LEN_OFS     = 12,
   parameter int MIN_PAYLOAD = 46
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      fire,
   input  logic [CNT_W-1:0]          idx,
   input  logic [rxs_pkg::BYTE_W-1:0] byte_in,
   input  logic                      en_cur,
   output logic                      dec_now,
   output logic [CNT_W-1:0]          lim_now
);
   localparam int HDR_LEN = LEN_OFS + 2;

   logic [rxs_pkg::BYTE_W-1:0] hi_q;
   logic [15:0]                len_word;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_q <= '0;
      else if (fire && idx == CNT_W'(LEN_OFS))
         hi_q <= byte_in;
   end

   always_comb begin
      len_word = {hi_q, byte_in};
      dec_now  = en_cur && (len_word < 16'(MIN_PAYLOAD));
      lim_now  = CNT_W'(HDR_LEN) + CNT_W'(len_word);
   end
endmodule

// File: rtl/rxs_frame_track.sv
// Tracks the byte position in the frame, decides which bytes are kept and
// where the end marker falls, and consumes dropped bytes without stalling.
module rxs_frame_track #(
   parameter int CNT_W       = 16,
   parameter int LEN_OFS     = 12,
   parameter int MIN_PAYLOAD = 46
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      strip_en,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [rxs_pkg::BYTE_W-1:0] in_data,
   input  logic                      in_sof,
   input  logic                      in_eof,
   input  logic                      acc,
   output logic                      fwd_valid,
   output rxs_pkg::rxs_beat_t        fwd_beat
);
   localparam int               HDR_LEN = LEN_OFS + 2;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] idx_q, lim_q, idx, cur_lim, lim_now;
   logic             en_q, strip_q, en_cur, at_len, cur_strip, dec_now;
   logic             keep, cut_end, fire;

   rxs_len_decode #(
      .CNT_W      (CNT_W),
      .LEN_OFS    (LEN_OFS),
      .MIN_PAYLOAD(MIN_PAYLOAD)
   ) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .idx    (idx),
      .byte_in(in_data),
      .en_cur (en_cur),
      .dec_now(dec_now),
      .lim_now(lim_now)
   );

   always_comb begin
      idx       = in_sof ? '0 : idx_q;
      en_cur    = in_sof ? strip_en : en_q;
      at_len    = (idx == CNT_W'(LEN_OFS + 1));
      cur_strip = in_sof ? 1'b0 : (at_len ? dec_now : strip_q);
      cur_lim   = at_len ? lim_now : lim_q;
      keep      = (idx < CNT_W'(HDR_LEN)) || !cur_strip || (idx < cur_lim);
      cut_end   = cur_strip && (idx == cur_lim - CNT_W'(1));
      fwd_valid = in_valid && keep;
      in_ready  = keep ? acc : 1'b1;
      fire      = in_valid && in_ready;
      fwd_beat.data = in_data;
      fwd_beat.sof  = in_sof;
      fwd_beat.eof  = in_eof || cut_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         lim_q   <= '0;
         en_q    <= 1'b0;
         strip_q <= 1'b0;
      end else if (fire) begin
         en_q    <= en_cur;
         lim_q   <= cur_lim;
         strip_q <= in_eof ? 1'b0 : cur_strip;
         if (in_eof)
            idx_q <= '0;
         else if (idx != CNT_MAX)
            idx_q <= idx + CNT_W'(1);
         else
            idx_q <= idx;
      end
   end
endmodule

// File: rtl/rxs_out_stage.sv
// Output stage: a full-throughput register or a plain pass-through.
module rxs_out_stage #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fwd_valid,
   input  rxs_pkg::rxs_beat_t fwd_beat,
   output logic               acc,
   output logic               out_valid,
   input  logic               out_ready,
   output rxs_pkg::rxs_beat_t out_beat
);
   generate
      if (OUT_REG) begin : g_reg
         logic               v_q;
         rxs_pkg::rxs_beat_t b_q;

         assign acc       = !v_q || out_ready;
         assign out_valid = v_q;
         assign out_beat  = b_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               b_q <= '0;
            end else if (acc) begin
               v_q <= fwd_valid;
               if (fwd_valid)
                  b_q <= fwd_beat;
            end
         end
      end else begin : g_wire
         assign acc       = out_ready;
         assign out_valid = fwd_valid;
         assign out_beat  = fwd_beat;
      end
   endgenerate
endmodule

// File: rtl/rx_pad_strip.sv
module rx_pad_strip #(
   parameter int CNT_W       = 16,
   parameter int LEN_OFS     = 12,
   parameter int MIN_PAYLOAD = 46,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strip_en,
   input  logic       csum_en,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_sof,
   input  logic       in_eof,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data,
   output logic       out_sof,
   output logic       out_eof,
   output logic       cfg_conflict
);
   localparam int HDR_LEN = LEN_OFS + 2;

   initial begin
      assert (CNT_W >= 8 && CNT_W <= 32)
         else $error("rx_pad_strip: CNT_W out of range");
      assert (LEN_OFS >= 0)
         else $error("rx_pad_strip: LEN_OFS negative");
      assert (MIN_PAYLOAD > 0 && (HDR_LEN + MIN_PAYLOAD) < (1 << CNT_W))
         else $error("rx_pad_strip: MIN_PAYLOAD does not fit CNT_W");
   end

   logic               acc, fwd_valid;
   rxs_pkg::rxs_beat_t fwd_beat, out_beat;

   rxs_frame_track #(
      .CNT_W      (CNT_W),
      .LEN_OFS    (LEN_OFS),
      .MIN_PAYLOAD(MIN_PAYLOAD)
   ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .strip_en (strip_en),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_sof   (in_sof),
      .in_eof   (in_eof),
      .acc      (acc),
      .fwd_valid(fwd_valid),
      .fwd_beat (fwd_beat)
   );

   rxs_out_stage #(
      .OUT_REG(OUT_REG)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .fwd_valid(fwd_valid),
      .fwd_beat (fwd_beat),
      .acc      (acc),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_beat (out_beat)
   );

   assign out_data     = out_beat.data;
   assign out_sof      = out_beat.sof;
   assign out_eof      = out_beat.eof;
   assign cfg_conflict = strip_en && csum_en;
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_sof,
   input logic       out_eof
);
   logic in_frame;

   always_ff @(posedge clk) begin
      if (!rst_n)
         in_frame <= 1'b0;
      else if (out_valid && out_ready)
         in_frame <= !out_eof;
   end

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);

   a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));

   a_r8_frame_opens_with_sof: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !in_frame) |-> out_sof);

   a_r8_no_sof_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && in_frame) |-> !out_sof);
endmodule

bind rx_pad_strip rxs_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .out_sof  (out_sof),
   .out_eof  (out_eof)
);

// File: tb/sim_rx_pad_strip.sv
`timescale 1ns/1ps
module sim_rx_pad_strip;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strip_en = 1'b0, csum_en = 1'b0;
   logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready, out_valid, out_sof, out_eof, cfg_conflict;
   logic [7:0] out_data;
   logic       out_ready = 1'b0;

   int   checks = 0, errors = 0;
   bit   done = 1'b0, hold = 1'b0, fast = 1'b0;
   logic [7:0] lfsr = 8'h5a;

   logic [9:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   rx_pad_strip u0 (
      .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .csum_en(csum_en),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
      .out_eof(out_eof), .cfg_conflict(cfg_conflict)
   );

   // ready pattern changes just after each rising edge
   always @(posedge clk) begin
      #1;
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= hold ? 1'b0 : (fast ? 1'b1 : (lfsr[0] | lfsr[2]));
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected byte actual %h/%b/%b expected none",
                     out_data, out_sof, out_eof);
         end else begin
            logic [9:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({out_data, out_sof, out_eof} !== e) begin
               errors++;
               $display("FAIL %s actual %h/%b/%b expected %h/%b/%b", t,
                        out_data, out_sof, out_eof, e[9:2], e[1], e[0]);
            end
         end
      end
   end

   function automatic logic [7:0] byte_of(int i, int lf, logic [7:0] seed);
      if (i == 12) return lf[15:8];
      if (i == 13) return lf[7:0];
      return seed + 8'(i * 7);
   endfunction

   task automatic send_frame(input int lf, input int total, input bit en,
                             input bit flip, input bit stall_drop,
                             input logic [7:0] seed, input string tag);
      bit strip;
      int keep_n;
      strip  = en && (lf < 46);
      keep_n = strip ? ((14 + lf < total) ? 14 + lf : total) : total;
      for (int i = 0; i < keep_n; i++) begin
         exp_q.push_back({byte_of(i, lf, seed), i == 0, i == keep_n - 1});
         tag_q.push_back(tag);
      end
      strip_en = en;
      for (int i = 0; i < total; i++) begin
         if (flip && i == 5) strip_en = !en;
         if (stall_drop && i == keep_n) hold = 1'b1;
         in_valid = 1'b1;
         in_data  = byte_of(i, lf, seed);
         in_sof   = (i == 0);
         in_eof   = (i == total - 1);
         @(negedge clk);
         if (stall_drop && i >= keep_n) begin
            checks++;
            if (!in_ready) begin
               errors++;
               $display("FAIL R9 dropped byte %0d in_ready actual 0 expected 1", i);
            end
         end
         while (!in_ready) @(negedge clk);
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
      hold     = 1'b0;
      strip_en = en;
   endtask

   task automatic check_conflict(input bit s, input bit c);
      strip_en = s;
      csum_en  = c;
      #1;
      checks++;
      if (cfg_conflict !== (s & c)) begin
         errors++;
         $display("FAIL R7 cfg_conflict actual %b expected %b", cfg_conflict, s & c);
      end
   endtask

   task automatic drain();
      for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(posedge clk);
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R8 bytes missing actual %0d expected 0", exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 out_valid in reset actual %b expected 0", out_valid);
      end
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 out_valid after reset actual %b expected 0", out_valid);
      end
      @(posedge clk);
      #1;

      // R7 conflict flag over all four combinations
      check_conflict(1'b0, 1'b0);
      check_conflict(1'b1, 1'b0);
      check_conflict(1'b0, 1'b1);
      check_conflict(1'b1, 1'b1);
      csum_en = 1'b0;

      send_frame(10, 64, 1'b1, 1'b0, 1'b0, 8'h10, "R2 R3 len10 stripped");
      send_frame(0, 64, 1'b1, 1'b0, 1'b0, 8'h20, "R11 len0 eof on byte 13");
      send_frame(45, 64, 1'b1, 1'b0, 1'b0, 8'h30, "R2 len45 boundary");
      send_frame(46, 64, 1'b1, 1'b0, 1'b0, 8'h40, "R4 len46 unmodified");
      send_frame(16'h0800, 70, 1'b1, 1'b0, 1'b0, 8'h50, "R5 type code unmodified");
      send_frame(10, 64, 1'b0, 1'b0, 1'b0, 8'h60, "R6 strip off unmodified");
      send_frame(40, 30, 1'b1, 1'b0, 1'b0, 8'h70, "R11 truncated frame");
      send_frame(5, 64, 1'b1, 1'b1, 1'b0, 8'h80, "R10 enable dropped mid-frame");
      send_frame(5, 64, 1'b0, 1'b1, 1'b0, 8'h90, "R10 enable raised mid-frame");
      drain();

      send_frame(4, 64, 1'b1, 1'b0, 1'b1, 8'ha0, "R9 drop while stalled");
      drain();

      fast = 1'b1;
      for (int f = 0; f < 6; f++)
         send_frame((f % 2) ? 20 + f : 100, 64 + f, 1'b1, 1'b0, 1'b0,
                    8'(f * 17), "R8 back-to-back frames");
      fast = 1'b0;
      for (int f = 0; f < 4; f++)
         send_frame(f * 12, 66, 1'b1, 1'b0, 1'b0, 8'(f * 29 + 3), "R2 R3 random ready");
      drain();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule